// File: doc/BRIEF.md
# Sixteen-Function Status-Flag ALU

This block is the arithmetic and logic stage of a datapath. It takes two operands and a 4-bit operation code, and it produces a result together with four status bits: overflow, carry, negative and zero. The whole block is combinational, so the result and the flags follow the inputs within the same cycle. The operand width is a parameter, and it defaults to 16 bits.

The sixteen operation codes cover arithmetic, bitwise logic, shifts and plain transfers. A carry-in or borrow-in is never taken from an earlier result. It comes only from the operation code, because some codes add an extra one and others do not.

Next to the flags, the block drives a 4-bit update mask. The mask tells the flag register which status bits the current code defines. Any flag outside the mask is driven low.

Top module: `flag_alu`

## Requirements
- R1: Code 0000 gives Y = A. Code 0111 gives Y = B.
- R2: Code 0001 gives Y = A+1. Code 0110 gives Y = A−1. Both wrap modulo 2^N.
- R3: Code 0010 gives Y = A+B. Code 0011 gives Y = A+B+1.
- R4: Code 0100 gives Y = A+~B, which is A−B−1. Code 0101 gives Y = A+~B+1, which is A−B.
- R5: Code 1000 gives A|B. Code 1001 gives A&B. Code 1010 gives A^B. Code 1011 gives ~A. Code 1100 gives ~B.
- R6: Code 1101 shifts B right by one place and fills the top bit with 0. Code 1110 shifts B left by one place and fills bit 0 with 0.
- R7: Code 1111 gives Y = 0, and all four flag outputs and the mask are 0.
- R8: For codes 0001 to 0110, the block adds A to a second term and a carry-in chosen by the code.
  - The second term is 0 for 0001, B for 0010 and 0011, ~B for 0100 and 0101, and all ones for 0110.
  - The carry-in is 1 for 0001, 0011 and 0101, and 0 for the other codes in this range.
  - C is the carry out of bit N−1 of that N-bit sum.
  - V is 1 when the signed sum falls outside the N-bit two's-complement range.
- R9: Whenever a code updates N and Z, N equals Y[N−1] and Z is 1 exactly when Y is all zeros.
- R10: Mask bit 3 stands for V, bit 2 for C, bit 1 for N and bit 0 for Z.
  - The mask is 1111 for codes 0001 to 0110.
  - The mask is 0000 for code 1111.
  - The mask is 0011 for every other code.
  - A flag output whose mask bit is 0 reads 0.
- R11: Outputs depend only on the present A, B and code. A carry produced by an earlier operation never changes a later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| fn_i | input | 4 | Operation code |
| y_o | output | WIDTH | Result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Adder carry out |
| n_o | output | 1 | Result sign bit |
| z_o | output | 1 | Result is zero |
| upd_o | output | 4 | Flag update mask {V,C,N,Z} |

## Verification
The key interaction is between the carry flag and the overflow flag: both come from one adder, and they must be judged independently within a single operation. Directed operands are chosen to exercise each combination:
- 0x8000+0x8000 sets both carry and overflow, and gives a zero result.
- 0x7FFF+1 sets overflow without carry.
- 0xFFFF+1 sets carry and zero without overflow.

Random operands, with known edge values mixed in, cover the remaining combinations. A reference model in the bench works out true signed and unsigned sums at full precision and judges every flag from them. A carry-producing operation is placed directly before a plain add on the same operands, to show that the earlier carry never leaks into the later result.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    FN_PASS_A = 4'h0,
    FN_INC    = 4'h1,
    FN_ADD    = 4'h2,
    FN_ADD1   = 4'h3,
    FN_SUB1   = 4'h4,
    FN_SUB    = 4'h5,
    FN_DEC    = 4'h6,
    FN_PASS_B = 4'h7,
    FN_OR     = 4'h8,
    FN_AND    = 4'h9,
    FN_XOR    = 4'hA,
    FN_NOT_A  = 4'hB,
    FN_NOT_B  = 4'hC,
    FN_SHR_B  = 4'hD,
    FN_SHL_B  = 4'hE,
    FN_CLEAR  = 4'hF
  } alu_fn_e;

  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;

  function automatic logic fn_is_arith(logic [3:0] fn);
    return (fn >= 4'h1) && (fn <= 4'h6);
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fn_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] op_y;
  logic             cin;
  logic [WIDTH:0]   full;

  // second addend and carry-in both come from the code alone
  always_comb begin
    op_y = '0;
    cin  = 1'b0;
    case (fn_i)
      FN_INC:  begin op_y = '0;   cin = 1'b1; end
      FN_ADD:  begin op_y = b_i;  cin = 1'b0; end
      FN_ADD1: begin op_y = b_i;  cin = 1'b1; end
      FN_SUB1: begin op_y = ~b_i; cin = 1'b0; end
      FN_SUB:  begin op_y = ~b_i; cin = 1'b1; end
      FN_DEC:  begin op_y = '1;   cin = 1'b0; end
      default: begin op_y = '0;   cin = 1'b0; end
    endcase
  end

  assign full   = {1'b0, a_i} + {1'b0, op_y} + {{WIDTH{1'b0}}, cin};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (a_i[MSB] == op_y[MSB]) && (full[MSB] != a_i[MSB]);

  always_comb begin
    if (fn_i == FN_INC && a_i == '1)
      AST_INC_WRAP: assert (sum_o == '0 && cout_o) else $error("inc wrap"); // R2
    if (fn_i == FN_DEC && a_i == '0)
      AST_DEC_WRAP: assert (sum_o == '1 && !cout_o) else $error("dec wrap"); // R2
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fn_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic from_hi;
    logic from_lo;

    if (g == MSB) begin : g_top
      assign from_hi = 1'b0;
    end else begin : g_mid_hi
      assign from_hi = b_i[g+1];
    end

    if (g == 0) begin : g_bot
      assign from_lo = 1'b0;
    end else begin : g_mid_lo
      assign from_lo = b_i[g-1];
    end

    always_comb begin
      case (fn_i)
        FN_PASS_A: res_o[g] = a_i[g];
        FN_PASS_B: res_o[g] = b_i[g];
        FN_OR:     res_o[g] = a_i[g] | b_i[g];
        FN_AND:    res_o[g] = a_i[g] & b_i[g];
        FN_XOR:    res_o[g] = a_i[g] ^ b_i[g];
        FN_NOT_A:  res_o[g] = ~a_i[g];
        FN_NOT_B:  res_o[g] = ~b_i[g];
        FN_SHR_B:  res_o[g] = from_hi;
        FN_SHL_B:  res_o[g] = from_lo;
        default:   res_o[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (fn_i == FN_SHR_B)
      AST_SHR_FILL: assert (!res_o[MSB]) else $error("shr fill"); // R6
    if (fn_i == FN_SHL_B)
      AST_SHL_FILL: assert (!res_o[0]) else $error("shl fill"); // R6
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       fn_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  output logic [FLG_W-1:0] upd_o,
  output logic [FLG_W-1:0] flg_o
);
  logic [FLG_W-1:0] raw;

  always_comb begin
    if (fn_is_arith(fn_i))       upd_o = 4'b1111;
    else if (fn_i == FN_CLEAR)   upd_o = 4'b0000;
    else                         upd_o = 4'b0011;
  end

  always_comb begin
    raw        = '0;
    raw[FLG_V] = ovf_i;
    raw[FLG_C] = cout_i;
    raw[FLG_N] = y_i[WIDTH-1];
    raw[FLG_Z] = (y_i == '0);
  end

  assign flg_o = raw & upd_o;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fn_i,
  output logic [WIDTH-1:0] y_o,
  output logic             v_o,
  output logic             c_o,
  output logic             n_o,
  output logic             z_o,
  output logic [3:0]       upd_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] bit_res;
  logic             cout;
  logic             ovf;
  logic [FLG_W-1:0] flg;
  logic [FLG_W-1:0] upd;

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i(a_i), .b_i(b_i), .fn_i(fn_i),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  alu_bitops #(.WIDTH(WIDTH)) u_bitops (
    .a_i(a_i), .b_i(b_i), .fn_i(fn_i), .res_o(bit_res)
  );

  assign y_o = fn_is_arith(fn_i) ? sum : bit_res;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .fn_i(fn_i), .y_i(y_o), .cout_i(cout), .ovf_i(ovf),
    .upd_o(upd), .flg_o(flg)
  );

  assign v_o   = flg[FLG_V];
  assign c_o   = flg[FLG_C];
  assign n_o   = flg[FLG_N];
  assign z_o   = flg[FLG_Z];
  assign upd_o = upd;

  always_comb begin
    if (fn_i == FN_PASS_B)
      AST_XFER_B: assert (y_o == b_i) else $error("xfer b"); // R1
    if (fn_i == FN_CLEAR)
      AST_CLEAR: assert (y_o == '0 && upd_o == 4'b0 && !v_o && !c_o && !n_o && !z_o) else $error("clear"); // R7
    if (fn_is_arith(fn_i))
      AST_ARITH_MASK: assert (upd_o == 4'b1111) else $error("arith mask"); // R10
    AST_UNMASKED_LOW: assert (({v_o, c_o, n_o, z_o} & ~upd_o) == 4'b0) else $error("unmasked flag"); // R10
    if (upd_o[FLG_Z])
      AST_ZERO_FLAG: assert (z_o == (y_o == '0)) else $error("zero flag"); // R9
    if (upd_o[FLG_N])
      AST_NEG_FLAG: assert (n_o == y_o[MSB]) else $error("neg flag"); // R9
  end

endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam longint MODV = 64'sd1 << W;
  localparam longint SMAX = (64'sd1 << (W - 1)) - 1;
  localparam longint SMIN = -(64'sd1 << (W - 1));

  logic clk = 1'b0;
  logic [W-1:0] a, b, y;
  logic [3:0] fn, upd;
  logic v, c, n, z;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flag_alu #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .fn_i(fn), .y_o(y),
    .v_o(v), .c_o(c), .n_o(n), .z_o(z), .upd_o(upd)
  );

  // returns {y, V, C, N, Z, mask}
  function automatic logic [W+7:0] model(logic [W-1:0] ea, logic [W-1:0] eb, logic [3:0] ef);
    longint ua, ub, sa, sb, uy, sy, cin, tot, st;
    logic [W-1:0] ry;
    logic [3:0] m;
    logic ev, ec;
    ua = longint'(ea); ub = longint'(eb);
    sa = ea[W-1] ? ua - MODV : ua;
    sb = eb[W-1] ? ub - MODV : ub;
    ev = 1'b0; ec = 1'b0; m = 4'b0011; ry = '0;
    if (ef >= 4'h1 && ef <= 4'h6) begin
      m = 4'b1111;
      case (ef)
        4'h1: begin uy = 0; sy = 0; cin = 1; end
        4'h2: begin uy = ub; sy = sb; cin = 0; end
        4'h3: begin uy = ub; sy = sb; cin = 1; end
        4'h4: begin uy = MODV - 1 - ub; sy = -sb - 1; cin = 0; end
        4'h5: begin uy = MODV - 1 - ub; sy = -sb - 1; cin = 1; end
        default: begin uy = MODV - 1; sy = -1; cin = 0; end
      endcase
      tot = ua + uy + cin;
      st  = sa + sy + cin;
      ry  = W'(tot % MODV);
      ec  = tot >= MODV;
      ev  = (st > SMAX) || (st < SMIN);
    end else begin
      case (ef)
        4'h0: ry = ea;
        4'h7: ry = eb;
        4'h8: ry = ea | eb;
        4'h9: ry = ea & eb;
        4'hA: ry = ea ^ eb;
        4'hB: ry = ~ea;
        4'hC: ry = ~eb;
        4'hD: ry = W'(ub / 2);
        4'hE: ry = W'((ub * 2) % MODV);
        default: begin ry = '0; m = 4'b0000; end
      endcase
    end
    return {ry, ({ev, ec, ry[W-1], ry == '0} & m), m};
  endfunction

  function automatic string req_of(logic [3:0] ef);
    case (ef)
      4'h0, 4'h7: return "R1";
      4'h1, 4'h6: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5: return "R4";
      4'hD, 4'hE: return "R6";
      4'hF: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(logic [W-1:0] ia, logic [W-1:0] ib, logic [3:0] ifn, string ytag);
    logic [W+7:0] e;
    @(posedge clk);
    a = ia; b = ib; fn = ifn;
    @(negedge clk);
    e = model(ia, ib, ifn);
    check(ytag, y, e[W+7:8]);
    check("R8/R9 flags", {{(W-4){1'b0}}, v, c, n, z}, {{(W-4){1'b0}}, e[7:4]});
    check("R10 mask", {{(W-4){1'b0}}, upd}, {{(W-4){1'b0}}, e[3:0]});
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 8)
      0: return '0;
      1: return W'(1);
      2: return {1'b0, {(W-1){1'b1}}};
      3: return {1'b1, {(W-1){1'b0}}};
      4: return '1;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    a = '0; b = '0; fn = 4'h0;
    // every code once at a simple point
    for (int k = 0; k < 16; k++) run(16'h1234, 16'h0F0F, 4'(k), req_of(4'(k)));
    // carry/overflow corners (R8)
    run(16'h7FFF, 16'h0001, 4'h2, "R8 ovf no carry");
    run(16'hFFFF, 16'h0001, 4'h2, "R8 carry zero");
    run(16'h8000, 16'h8000, 4'h2, "R8 carry and ovf");
    run(16'h8000, 16'h0001, 4'h5, "R4 sub ovf");
    run(16'h0005, 16'h0005, 4'h5, "R4 equal sub");
    run(16'h0005, 16'h0005, 4'h4, "R4 sub minus one");
    run(16'hFFFF, 16'h0000, 4'h1, "R2 inc wrap");
    run(16'h0000, 16'h0000, 4'h6, "R2 dec wrap");
    run(16'h7FFF, 16'h0000, 4'h1, "R2 inc ovf");
    run(16'h8001, 16'h8001, 4'hD, "R6 shr fill");
    run(16'h8001, 16'h8001, 4'hE, "R6 shl fill");
    run(16'hFFFF, 16'hFFFF, 4'hF, "R7 clear");
    // earlier carry must not leak (R11)
    run(16'hFFFF, 16'hFFFF, 4'h3, "R11 prior carry op");
    run(16'h0001, 16'h0002, 4'h2, "R11 add after carry");
    run(16'hFFFF, 16'h0001, 4'h2, "R11 repeat a");
    run(16'hFFFF, 16'h0001, 4'h2, "R11 repeat b");
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] rf;
      rf = 4'($urandom % 16);
      run(pick(), pick(), rf, req_of(rf));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule